// File: doc/BRIEF.md
# Traffic Light Phase Controller

A timed sequencer for a single three-lamp signal. A prescaler divides the system clock down to a one-second tick. Each tick advances a 23-second cycle: green for 10 seconds, yellow for 3 seconds, then red for 10 seconds, and the cycle repeats. Alongside the lamps the block produces a countdown for a two-digit seven-segment display and a one-bit selector that chooses between two 8x8 dot-matrix images.

The countdown treats green and yellow as one interval. It falls from 13 to 1, so the display reaches 3 when yellow begins. Red has its own shorter count. The display stays dark for the first three seconds of red, then counts 7 down to 1. The value leaves the block as two BCD digits with separate enable flags. Segment encoding, matrix row scanning and button debouncing happen outside this block.

An asynchronous reset or the synchronous `restart_i` button puts the block into its start state. In that state the green lamp is lit, the display shows 13 and the red image is selected. The first tick after that moves the display to 12 and selects the green image, and the block stays in the green phase.

Top module: `traffic_phase_ctrl`

## Requirements
- R1: Ticks step the phases in a fixed order: green for 10 ticks, yellow for 3, red for 10, then back to green. The full cycle is 23 ticks.
- R2: Exactly one of `lamp_green_o`, `lamp_yellow_o`, `lamp_red_o` is high whenever reset is not asserted.
- R3: Across green and yellow the displayed value is 13 at the start of green and falls by one on each tick. It reaches 4 on the last green second and shows 3, 2, 1 during yellow.
- R4: During the first 3 ticks of red both digits are blanked. The last 7 ticks of red show 7, 6, 5, 4, 3, 2, 1.
- R5: From the first tick after reset, `img_sel_o` is 0 (image 1) in green and yellow and 1 (image 2) in red.
- R6: Reset gives the start state: green lamp, value 13, `img_sel_o`=1. This state holds until the first tick. The first tick gives value 12 with the green lamp still lit.
- R7: The value appears as BCD. `tens_o` is the tens digit and `ones_o` is the ones digit. `tens_on_o` is 0 when the tens digit is zero. A digit whose enable is 0 outputs 0.
- R8: When `restart_i` is high at a clock edge, the block enters the R6 start state on that edge. The same edge clears the prescaler, so the next tick comes `TICK_DIV` clocks later.
- R9: A tick occurs once every `TICK_DIV` clocks, counted from reset or restart. No output changes between ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Synchronous restart, active high, from a debounced button |
| lamp_green_o | output | 1 | Green lamp |
| lamp_yellow_o | output | 1 | Yellow lamp |
| lamp_red_o | output | 1 | Red lamp |
| img_sel_o | output | 1 | Image select: 0 = image 1, 1 = image 2 |
| tens_on_o | output | 1 | Tens digit enable |
| tens_o | output | 4 | Tens digit, BCD |
| ones_on_o | output | 1 | Ones digit enable |
| ones_o | output | 4 | Ones digit, BCD |

## Verification
The hardest state to reach from the ports is the second pass through the cycle. There the lamp is green and the display shows 13, as it does after reset, but the image must now be image 1 instead of image 2. The stimulus runs two full 23-tick cycles with a short prescaler so the bench sees this wrap. It also samples one clock before every tick to show that nothing moves early. A restart is then issued during the red lead-in and an asynchronous reset during yellow. After each one the bench counts clocks to confirm that the tick schedule starts again from zero.

// File: rtl/tl_pkg.sv
package tl_pkg;
  typedef enum logic [1:0] {
    PH_GREEN  = 2'd0,
    PH_YELLOW = 2'd1,
    PH_RED    = 2'd2
  } phase_e;
endpackage

// File: rtl/tl_prescaler.sv
module tl_prescaler #(
  parameter int TICK_DIV = 200_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CNT_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (tick_o)   cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  // ticks are never back to back (TICK_DIV >= 2)
  p_tick_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tl_sequencer.sv
module tl_sequencer
  import tl_pkg::*;
#(
  parameter int GREEN_SEC  = 10,
  parameter int YELLOW_SEC = 3,
  parameter int RED_SEC    = 10,
  parameter int RED_COUNT  = 7,
  parameter int VAL_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             tick_i,
  output phase_e           phase_o,
  output logic [VAL_W-1:0] val_o,
  output logic             val_on_o,
  output logic             img_o
);
  localparam int CYCLE  = GREEN_SEC + YELLOW_SEC + RED_SEC;
  localparam int GY_SEC = GREEN_SEC + YELLOW_SEC;
  localparam int POS_W  = $clog2(CYCLE);
  localparam logic [POS_W-1:0] POS_LAST  = POS_W'(CYCLE - 1);
  localparam logic [POS_W-1:0] POS_YEL   = POS_W'(GREEN_SEC);
  localparam logic [POS_W-1:0] POS_RED   = POS_W'(GY_SEC);
  localparam logic [POS_W-1:0] POS_COUNT = POS_W'(GY_SEC + RED_SEC - RED_COUNT);

  logic [POS_W-1:0] pos_q, pos_nxt;
  logic             img_q;

  assign pos_nxt = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      img_q <= 1'b1;
    end else if (restart_i) begin
      pos_q <= '0;
      img_q <= 1'b1;
    end else if (tick_i) begin
      pos_q <= pos_nxt;
      img_q <= (pos_nxt >= POS_RED);
    end
  end

  always_comb begin
    phase_o  = PH_RED;
    val_on_o = 1'b1;
    val_o    = '0;
    if (pos_q < POS_YEL) begin
      phase_o = PH_GREEN;
      val_o   = VAL_W'(GY_SEC - int'(pos_q));
    end else if (pos_q < POS_RED) begin
      phase_o = PH_YELLOW;
      val_o   = VAL_W'(GY_SEC - int'(pos_q));
    end else if (pos_q < POS_COUNT) begin
      val_on_o = 1'b0;  // red lead-in: display dark
    end else begin
      val_o = VAL_W'(CYCLE - int'(pos_q));
    end
  end

  assign img_o = img_q;

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !restart_i) |=> ($stable(pos_q) && $stable(img_q)));
  p_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !restart_i && pos_q == POS_LAST) |=> (pos_q == '0));
  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (pos_q == '0 && img_q));
endmodule

// File: rtl/tl_digits.sv
module tl_digits #(
  parameter int VAL_W = 4
) (
  input  logic [VAL_W-1:0] val_i,
  input  logic             on_i,
  output logic             tens_on_o,
  output logic [3:0]       tens_o,
  output logic             ones_on_o,
  output logic [3:0]       ones_o
);
  logic [3:0] tens, ones;

  always_comb begin
    tens = 4'(int'(val_i) / 10);
    ones = 4'(int'(val_i) % 10);
  end

  assign tens_on_o = on_i && (tens != 4'd0);
  assign ones_on_o = on_i;
  assign tens_o    = tens_on_o ? tens : 4'd0;
  assign ones_o    = on_i ? ones : 4'd0;
endmodule

// File: rtl/traffic_phase_ctrl.sv
module traffic_phase_ctrl
  import tl_pkg::*;
#(
  parameter int TICK_DIV   = 200_000_000,
  parameter int GREEN_SEC  = 10,
  parameter int YELLOW_SEC = 3,
  parameter int RED_SEC    = 10,
  parameter int RED_COUNT  = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  output logic       lamp_green_o,
  output logic       lamp_yellow_o,
  output logic       lamp_red_o,
  output logic       img_sel_o,
  output logic       tens_on_o,
  output logic [3:0] tens_o,
  output logic       ones_on_o,
  output logic [3:0] ones_o
);
  localparam int GY_SEC = GREEN_SEC + YELLOW_SEC;
  localparam int MAX_V  = (GY_SEC > RED_COUNT) ? GY_SEC : RED_COUNT;
  localparam int VAL_W  = $clog2(MAX_V + 1);

  logic             tick;
  phase_e           phase;
  logic [VAL_W-1:0] val;
  logic             val_on;

  tl_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (restart_i),
    .tick_o(tick)
  );

  tl_sequencer #(
    .GREEN_SEC (GREEN_SEC),
    .YELLOW_SEC(YELLOW_SEC),
    .RED_SEC   (RED_SEC),
    .RED_COUNT (RED_COUNT),
    .VAL_W     (VAL_W)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart_i),
    .tick_i   (tick),
    .phase_o  (phase),
    .val_o    (val),
    .val_on_o (val_on),
    .img_o    (img_sel_o)
  );

  tl_digits #(.VAL_W(VAL_W)) u_dig (
    .val_i    (val),
    .on_i     (val_on),
    .tens_on_o(tens_on_o),
    .tens_o   (tens_o),
    .ones_on_o(ones_on_o),
    .ones_o   (ones_o)
  );

  assign lamp_green_o  = (phase == PH_GREEN);
  assign lamp_yellow_o = (phase == PH_YELLOW);
  assign lamp_red_o    = (phase == PH_RED);

  p_one_lamp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({lamp_green_o, lamp_yellow_o, lamp_red_o}));
  p_img_follows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !restart_i) |=> (img_sel_o == lamp_red_o));
  p_tens_blank_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tens_on_o |-> (tens_o != 4'd0));
  p_dark_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ones_on_o |-> (ones_o == 4'd0 && !tens_on_o));
endmodule

// File: tb/traffic_phase_ctrl_test.sv
`timescale 1ns/1ps
module traffic_phase_ctrl_test;
  localparam int DIV = 4;

  logic clk = 1'b0, rst_ni = 1'b0, restart_i = 1'b0;
  logic g, y, r, img, ton, oon;
  logic [3:0] tens, ones;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  traffic_phase_ctrl #(.TICK_DIV(DIV)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .restart_i(restart_i),
    .lamp_green_o(g), .lamp_yellow_o(y), .lamp_red_o(r),
    .img_sel_o(img), .tens_on_o(ton), .tens_o(tens),
    .ones_on_o(oon), .ones_o(ones)
  );

  // {g,y,r, img, tens_on, tens[3:0], ones_on, ones[3:0]} per tick count
  localparam logic [13:0] EXP [24] = '{
    14'b100_1_1_0001_1_0011, // 0 reset: 13, image 2
    14'b100_0_1_0001_1_0010, // 12
    14'b100_0_1_0001_1_0001, // 11
    14'b100_0_1_0001_1_0000, // 10
    14'b100_0_0_0000_1_1001, // 9
    14'b100_0_0_0000_1_1000,
    14'b100_0_0_0000_1_0111,
    14'b100_0_0_0000_1_0110,
    14'b100_0_0_0000_1_0101,
    14'b100_0_0_0000_1_0100, // 4, last green
    14'b010_0_0_0000_1_0011, // yellow 3
    14'b010_0_0_0000_1_0010,
    14'b010_0_0_0000_1_0001,
    14'b001_1_0_0000_0_0000, // red dark
    14'b001_1_0_0000_0_0000,
    14'b001_1_0_0000_0_0000,
    14'b001_1_0_0000_1_0111, // red 7
    14'b001_1_0_0000_1_0110,
    14'b001_1_0_0000_1_0101,
    14'b001_1_0_0000_1_0100,
    14'b001_1_0_0000_1_0011,
    14'b001_1_0_0000_1_0010,
    14'b001_1_0_0000_1_0001,
    14'b100_0_1_0001_1_0011  // wrap: 13, image 1
  };

  function automatic int idx(int k);
    return (k == 0) ? 0 : ((k - 1) % 23) + 1;
  endfunction

  task automatic chk(string tag, int k, logic [13:0] e);
    logic [13:0] a;
    a = {g, y, r, img, ton, tens, oon, ones};
    n_cmp++;
    if (a[13:11] !== e[13:11]) begin
      n_bad++;
      $display("FAIL R1/R2 %s k=%0d lamps act=%b exp=%b", tag, k, a[13:11], e[13:11]);
    end else if (a[10] !== e[10]) begin
      n_bad++;
      $display("FAIL R5 %s k=%0d img act=%b exp=%b", tag, k, a[10], e[10]);
    end else if (a[9:0] !== e[9:0]) begin
      n_bad++;
      $display("FAIL R3/R4/R7 %s k=%0d digits act=%b exp=%b", tag, k, a[9:0], e[9:0]);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R6 in reset", 0, EXP[0]);
    rst_ni = 1'b1;
    chk("R6 after release", 0, EXP[0]);

    // two full cycles; previous value must hold one clock before each tick (R9)
    for (int k = 1; k <= 46; k++) begin
      repeat (DIV - 1) @(negedge clk);
      chk("R9 hold before tick", k - 1, EXP[idx(k - 1)]);
      @(negedge clk);
      chk("R1 table", k, EXP[idx(k)]);
    end

    // into the red lead-in (k=14), then restart (R8)
    repeat (14 * DIV) @(negedge clk);
    chk("R4 lead-in before restart", 14, EXP[14]);
    repeat (2) @(negedge clk);
    restart_i = 1'b1;
    @(negedge clk);
    restart_i = 1'b0;
    chk("R8 restart state", 0, EXP[0]);
    repeat (DIV - 1) @(negedge clk);
    chk("R8 prescaler cleared", 0, EXP[0]);
    @(negedge clk);
    chk("R8 R6 first tick", 1, EXP[1]);

    // async reset in yellow (k=11)
    repeat (10 * DIV) @(negedge clk);
    chk("R1 yellow", 11, EXP[11]);
    rst_ni = 1'b0;
    #1;
    chk("R6 async reset", 0, EXP[0]);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (DIV - 1) @(negedge clk);
    chk("R6 hold until tick", 0, EXP[0]);
    @(negedge clk);
    chk("R6 first tick 12", 1, EXP[1]);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule